// File: doc/BRIEF.md
# OFDM Frequency-Bin Mapper

This block assembles one frequency-domain OFDM symbol of 256 bins, ready for an inverse FFT. It receives a stream of complex data symbols and sends out one complex bin per cycle in natural bin order, from bin 0 up to bin 255. For each bin it picks the source. Guard-band bins and the DC bin carry a null value. Eight bins carry a fixed pilot. The remaining 192 bins take the next data symbol from the input. The pilot layout is fixed and is the same in every symbol.

Both sides use valid/ready handshakes, and the path from input to output is combinational. On a null or a pilot bin the output is valid on its own and the input is not asked for a symbol. On a data bin the input handshake is passed through to the output. The output also carries the current bin index and a flag that marks the final bin of each symbol.

The layout is set by parameters. The low guard band has 28 bins and the high guard band has 27 bins. DC sits after the first 100 used bins. Pilots are placed every 25 used bins, counting from the first used bin. The pilot amplitude is a parameter.

Top module: `ofdm_bin_mapper`

## Requirements
- R1: While reset is held and right after it is released, out_bin is 0 and out_last is 0. The first bin sent after reset is bin 0.
- R2: Bins 0 to 27 (low guard) are sent as (0,0) with out_valid high, whatever in_valid or the input data is.
- R3: Bin 128 (DC) is sent as (0,0) with out_valid high.
- R4: Bins 229 to 255 (high guard) are sent as (0,0) with out_valid high.
- R5: Bins 28, 53, 78, 103, 129, 154, 179 and 204 are pilots. They are sent as (PILOT_AMP, 0) with out_valid high, and each symbol has exactly 8 of them.
- R6: Every other bin is a data bin. It carries the input symbols unchanged and in arrival order, and exactly 192 symbols are consumed per output symbol.
- R7: in_ready is high only on a data bin while out_ready is high. On a data bin, out_valid equals in_valid.
- R8: out_bin moves up by one on each output transfer. out_last is high exactly on bin 255, and the bin after it is bin 0 of the next symbol.
- R9: While out_valid is high and out_ready is low, out_bin does not change and no input symbol is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data symbol available |
| in_ready | output | 1 | Data symbol accepted this cycle |
| in_re | input | DW | Data symbol real part |
| in_im | input | DW | Data symbol imaginary part |
| out_valid | output | 1 | Output bin valid |
| out_ready | input | 1 | Downstream accepts the bin |
| out_re | output | DW | Bin value real part |
| out_im | output | DW | Bin value imaginary part |
| out_bin | output | log2(NFFT) | Index of the current bin |
| out_last | output | 1 | Final bin of the symbol |

## Verification
The assertions check the following on every cycle:
- the bin index steps by one, wraps after the final bin, and holds while the output is stalled;
- an input transfer only happens together with an output transfer;
- each completed symbol has consumed exactly 192 data symbols and emitted exactly 8 pilots.

Only the bench scenarios can show the rest. That covers the exact place of each pilot and null bin, and the pilot value. It also covers whether data leaves in arrival order and unchanged. These are checked while input gaps, output back-pressure and both together vary across several consecutive symbols.

// File: rtl/ofdm_map_pkg.sv
package ofdm_map_pkg;
   typedef enum logic [1:0] {
      BIN_NULL  = 2'd0,
      BIN_PILOT = 2'd1,
      BIN_DATA  = 2'd2
   } bin_kind_e;
endpackage

// File: rtl/ofdm_bin_counter.sv
module ofdm_bin_counter #(
   parameter int NFFT = 256,
   localparam int BW = $clog2(NFFT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   output logic [BW-1:0] bin,
   output logic          last
);
   localparam logic [BW-1:0] LAST_BIN = BW'(NFFT - 1);

   assign last = (bin == LAST_BIN);

   always_ff @(posedge clk) begin
      if (!rst_n)
         bin <= '0;
      else if (advance)
         bin <= last ? '0 : bin + 1'b1;
   end

   // R8: after the final bin the index returns to the first bin
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      advance && last |=> bin == '0);

   // R9: without an output transfer the index does not move
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(bin));
endmodule

// File: rtl/ofdm_bin_classify.sv
module ofdm_bin_classify
   import ofdm_map_pkg::*;
#(
   parameter int NFFT     = 256,
   parameter int GUARD_LO = 28,
   parameter int GUARD_HI = 27,
   parameter int NPILOT   = 8,
   localparam int BW = $clog2(NFFT)
) (
   input  logic [BW-1:0] bin,
   output bin_kind_e     kind
);
   localparam int NUSED  = NFFT - GUARD_LO - GUARD_HI - 1;
   localparam int HALF   = NUSED / 2;
   localparam int PSPACE = NUSED / NPILOT;
   localparam logic [BW-1:0] LO_B = BW'(GUARD_LO);
   localparam logic [BW-1:0] DC_B = BW'(GUARD_LO + HALF);
   localparam logic [BW-1:0] HI_B = BW'(GUARD_LO + 2 * HALF + 1);

   if ((1 << BW) != NFFT)
      $error("NFFT must be a power of two");
   if (NUSED % 2 != 0)
      $error("used bin count must be even around DC");
   if (NPILOT < 1 || NUSED % NPILOT != 0)
      $error("pilot count must divide the used bin count");

   logic          in_used;
   logic [BW-1:0] used_idx;
   logic [NPILOT-1:0] hit;

   always_comb begin
      in_used  = (bin >= LO_B && bin < DC_B) || (bin > DC_B && bin < HI_B);
      used_idx = (bin < DC_B) ? bin - LO_B : bin - LO_B - 1'b1;
   end

   for (genvar i = 0; i < NPILOT; i++) begin : g_pilot
      localparam logic [BW-1:0] POS = BW'(i * PSPACE);
      assign hit[i] = (used_idx == POS);
   end

   always_comb begin
      if (!in_used)
         kind = BIN_NULL;
      else if (|hit)
         kind = BIN_PILOT;
      else
         kind = BIN_DATA;
   end
endmodule

// File: rtl/ofdm_bin_mux.sv
module ofdm_bin_mux
   import ofdm_map_pkg::*;
#(
   parameter int DW        = 16,
   parameter int PILOT_AMP = 11585
) (
   input  bin_kind_e            kind,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);
   localparam logic signed [DW-1:0] AMP = DW'(PILOT_AMP);

   always_comb begin
      unique case (kind)
         BIN_DATA:  begin out_re = in_re; out_im = in_im; end
         BIN_PILOT: begin out_re = AMP;   out_im = '0;    end
         default:   begin out_re = '0;    out_im = '0;    end
      endcase
   end
endmodule

// File: rtl/ofdm_bin_mapper.sv
module ofdm_bin_mapper
   import ofdm_map_pkg::*;
#(
   parameter int DW        = 16,
   parameter int NFFT      = 256,
   parameter int GUARD_LO  = 28,
   parameter int GUARD_HI  = 27,
   parameter int NPILOT    = 8,
   parameter int PILOT_AMP = 11585,
   localparam int BW = $clog2(NFFT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im,
   output logic [BW-1:0]        out_bin,
   output logic                 out_last
);
   localparam int NDATA = NFFT - GUARD_LO - GUARD_HI - 1 - NPILOT;

   bin_kind_e kind;
   logic      out_fire;
   logic      in_fire;

   ofdm_bin_counter #(.NFFT(NFFT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .advance(out_fire),
      .bin(out_bin), .last(out_last)
   );

   ofdm_bin_classify #(.NFFT(NFFT), .GUARD_LO(GUARD_LO), .GUARD_HI(GUARD_HI),
                       .NPILOT(NPILOT)) u_cls (
      .bin(out_bin), .kind(kind)
   );

   ofdm_bin_mux #(.DW(DW), .PILOT_AMP(PILOT_AMP)) u_mux (
      .kind(kind), .in_re(in_re), .in_im(in_im),
      .out_re(out_re), .out_im(out_im)
   );

   assign out_valid = (kind != BIN_DATA) || in_valid;
   assign in_ready  = (kind == BIN_DATA) && out_ready;
   assign out_fire  = out_valid && out_ready;
   assign in_fire   = in_valid && in_ready;

   // per-symbol tallies used only by the assertions below
   logic [BW:0] data_cnt, pilot_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_cnt  <= '0;
         pilot_cnt <= '0;
      end else if (out_fire && out_last) begin
         data_cnt  <= '0;
         pilot_cnt <= '0;
      end else if (out_fire) begin
         if (in_fire)          data_cnt  <= data_cnt + 1'b1;
         if (out_im == '0 && kind == BIN_PILOT) pilot_cnt <= pilot_cnt + 1'b1;
      end
   end

   // R6: a complete symbol has consumed exactly NDATA input symbols
   p_data_per_symbol_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_last |-> data_cnt == (BW+1)'(NDATA));

   // R5: a complete symbol has carried exactly NPILOT pilots
   p_pilot_per_symbol_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_last |-> pilot_cnt == (BW+1)'(NPILOT));

   // R7: an input symbol is only taken together with an output transfer
   p_take_with_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire |-> out_fire);

   // R9: a stalled bin keeps its index in the next cycle
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_bin == $past(out_bin));
endmodule

// File: tb/ofdm_bin_mapper_test.sv
module ofdm_bin_mapper_test;
   localparam int DW = 16;
   localparam int A  = 11585;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic signed [DW-1:0] in_re = '0;
   logic signed [DW-1:0] in_im = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic signed [DW-1:0] out_re, out_im;
   logic [7:0] out_bin;
   logic out_last;

   always #4 clk = ~clk;

   ofdm_bin_mapper #(.DW(DW), .PILOT_AMP(A)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
      .out_re(out_re), .out_im(out_im), .out_bin(out_bin), .out_last(out_last)
   );

   int checks = 0;
   int fails  = 0;
   int symbols = 0;
   int cyc = 0;
   logic signed [DW-1:0] q_re[$];
   logic signed [DW-1:0] q_im[$];

   // 0 null, 1 pilot, 2 data
   function automatic int bin_kind(int b);
      int u;
      if (b < 28 || b == 128 || b > 228) return 0;
      u = (b < 128) ? b - 28 : b - 29;
      return (u % 25 == 0) ? 1 : 2;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // output-side ready pattern: back-pressure in symbols 2 and 3
   initial begin
      forever begin
         @(posedge clk); #1;
         if (rst_n && (symbols == 2 || symbols == 3))
            out_ready = (cyc % 5) != 1;
         else
            out_ready = rst_n;
      end
   end

   // driver: offers numbered symbols, pushes each into the scoreboard as offered
   initial begin
      int seq;
      bit took;
      seq = 0;
      in_re = DW'(seq * 37 + 5);
      in_im = -DW'(seq * 11 + 3);
      q_re.push_back(in_re);
      q_im.push_back(in_im);
      forever begin
         @(negedge clk);
         took = in_valid && in_ready;
         @(posedge clk); #1;
         if (took) begin
            seq++;
            in_re = DW'(seq * 37 + 5);
            in_im = -DW'(seq * 11 + 3);
            q_re.push_back(in_re);
            q_im.push_back(in_im);
         end
         if (rst_n && (symbols == 1 || symbols == 3))
            in_valid = (cyc % 3) != 0;
         else
            in_valid = rst_n;
      end
   end

   // monitor: compares each cycle against the layout computed here
   initial begin
      int tb_bin;
      int dcount;
      bit stalled;
      int k;
      tb_bin = 0;
      dcount = 0;
      stalled = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            check(out_bin == 0, "R1 bin in reset", out_bin, 0);
            check(out_last == 0, "R1 last in reset", out_last, 0);
            continue;
         end
         k = bin_kind(tb_bin);
         if (stalled) check(out_bin == tb_bin, "R9 bin held", out_bin, tb_bin);
         else         check(out_bin == tb_bin, "R8 bin index", out_bin, tb_bin);
         check(in_ready == (k == 2 && out_ready), "R7 in_ready", in_ready, k == 2 && out_ready);
         check(out_valid == (k != 2 || in_valid), "R7 out_valid", out_valid, k != 2 || in_valid);
         check(out_last == (tb_bin == 255), "R8 last flag", out_last, tb_bin == 255);
         if (out_valid && out_ready) begin
            if (k == 0) begin
               if (tb_bin < 28)       check(out_re == 0 && out_im == 0, "R2 low guard", out_re, 0);
               else if (tb_bin == 128) check(out_re == 0 && out_im == 0, "R3 DC bin", out_re, 0);
               else                   check(out_re == 0 && out_im == 0, "R4 high guard", out_re, 0);
            end else if (k == 1) begin
               check(out_re == A, "R5 pilot real", out_re, A);
               check(out_im == 0, "R5 pilot imag", out_im, 0);
            end else begin
               if (q_re.size() == 0) begin
                  check(1'b0, "R6 data underrun", out_re, 0);
               end else begin
                  check(out_re == q_re[0], "R6 data real", out_re, q_re[0]);
                  check(out_im == q_im[0], "R6 data imag", out_im, q_im[0]);
                  void'(q_re.pop_front());
                  void'(q_im.pop_front());
               end
               dcount++;
            end
            if (tb_bin == 255) begin
               check(dcount == 192, "R6 data per symbol", dcount, 192);
               dcount = 0;
               tb_bin = 0;
               symbols++;
            end else begin
               tb_bin++;
            end
            stalled = 1'b0;
         end else begin
            stalled = out_valid;
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      fork
         wait (symbols >= 5);
         begin
            repeat (200000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", symbols, 5);
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule